// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block computes a single-error-correcting Hamming code over a 512-byte NAND page. It watches the byte stream that passes through a flash data port. The page is handled as two independent 256-byte halves. Each half gets 16 bits of line parity and 6 bits of column parity. Line parity is indexed by the byte offset within the half. Column parity is indexed by bit position within each byte.

A host drives the block through an 8-bit mode register. The sequence is:

1. Write the clear code.
2. Perform any dummy transfer.
3. Write the calculate code and stream the page.
4. Write the result code.
5. Read the six code bytes as three 16-bit words.

Writing the plain data code then returns the port to ordinary transfers. All stored parity is inverted, so an erased page yields an all-ones code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After synchronous reset, `rd_word` is 0x0000, the mode is plain data (0x94), and the accumulators are empty. A readout without any accumulated bytes returns 0xFFFF three times.
- R2: Writing mode 0xF4 clears both halves' parity and the page byte counter on the next clock edge.
- R3: In mode 0xB4, each byte with `dat_valid` high is accumulated. Bytes 0..255 of the page feed the first half and bytes 256..511 feed the second half, counted from the last clear.
- R4: For index bit j (0..7) of a byte's offset within its half, line parity bit 2j+1 is the XOR of all bits of the bytes whose offset has bit j set. Bit 2j is the same over the bytes whose offset has bit j clear.
- R5: Column parity bit 0 covers byte bits {0,2,4,6}, bit 1 covers {1,3,5,7}, bit 2 covers {0,1,4,5}, bit 3 covers {2,3,6,7}, bit 4 covers {0..3} and bit 5 covers {4..7}. The column byte is {~CP5..~CP0, 2'b11}.
- R6: Every parity bit is returned inverted, so a page of 512 bytes of 0xFF gives three words of 0xFFFF.
- R7: In mode 0xD4, successive reads return words in this order, each word written {high byte, low byte}:
  1. {~LP15..8 of half A, ~LP7..0 of half A}
  2. {~LP7..0 of half B, CP byte of half A}
  3. {CP byte of half B, ~LP15..8 of half B}
- R8: After the third word the read order wraps to the first word. Writing mode 0xD4 again restarts the order at the first word.
- R9: Bytes transferred in any mode other than 0xB4 leave the parity unchanged. This covers a dummy read right after clear and transfers in mode 0x94 after readout.
- R10: Bytes beyond the 512th since the last clear are ignored.
- R11: A read strobe outside mode 0xD4 leaves `rd_word` unchanged. A readout result is returned one clock after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| dat_valid | input | 1 | A byte moves through the data port this cycle |
| dat_byte | input | 8 | Byte on the data port |
| rd_en | input | 1 | 16-bit result read strobe |
| rd_word | output | 16 | Registered result word |

## Verification
The checker enforces several rules on every cycle:
- A clear empties both halves.
- Parity never changes while the mode is not calculate, and never after the page is full.
- The byte counter never passes the page size.
- The read index stays below three.
- `rd_word` only moves on a read strobe in result mode.

The actual parity values, the byte order of the three words, and the wrap of the read order are shown only by the bench. It compares readouts of random, erased, sparse and partial pages against a parity model computed independently of the RTL.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam logic [7:0] MODE_DATA    = 8'h94;
  localparam logic [7:0] MODE_ECC_CLR = 8'hF4;
  localparam logic [7:0] MODE_ECC_RUN = 8'hB4;
  localparam logic [7:0] MODE_ECC_OUT = 8'hD4;

  localparam int BYTE_W  = 8;
  localparam int CP_W    = 6;
  localparam int WORD_W  = 16;
  localparam int N_WORDS = 3;

  // column parity of one byte, raw (not inverted)
  function automatic logic [CP_W-1:0] byte_col_par(input logic [BYTE_W-1:0] b);
    logic [CP_W-1:0] c;
    c[0] = ^(b & 8'h55);
    c[1] = ^(b & 8'hAA);
    c[2] = ^(b & 8'h33);
    c[3] = ^(b & 8'hCC);
    c[4] = ^(b & 8'h0F);
    c[5] = ^(b & 8'hF0);
    return c;
  endfunction
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
#(
  parameter int IDXW = 8,
  localparam int LPW = 2 * IDXW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [IDXW-1:0]   idx,
  input  logic [BYTE_W-1:0] din,
  output logic [LPW-1:0]    lp,
  output logic [CP_W-1:0]   cp
);
  logic [LPW-1:0] lp_toggle;
  logic           row_par;

  always_comb begin
    row_par   = ^din;
    lp_toggle = '0;
    for (int j = 0; j < IDXW; j++) begin
      if (idx[j]) lp_toggle[2*j+1] = row_par;
      else        lp_toggle[2*j]   = row_par;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ lp_toggle;
      cp <= cp ^ byte_col_par(din);
    end
  end
endmodule

// File: rtl/ecc_result_pack.sv
module ecc_result_pack
  import nand_ecc_pkg::*;
#(
  parameter int LPW = 16
) (
  input  logic [LPW-1:0]    lp_a,
  input  logic [CP_W-1:0]   cp_a,
  input  logic [LPW-1:0]    lp_b,
  input  logic [CP_W-1:0]   cp_b,
  input  logic [1:0]        sel,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] la, lb;
  logic [BYTE_W-1:0] ca, cb;

  always_comb begin
    la = ~(WORD_W'(lp_a));
    lb = ~(WORD_W'(lp_b));
    ca = {~cp_a, 2'b11};
    cb = {~cp_b, 2'b11};
    unique case (sel)
      2'd0:    word = {la[15:8], la[7:0]};
      2'd1:    word = {lb[7:0],  ca};
      default: word = {cb,       lb[15:8]};
    endcase
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [7:0]        mode_val,
  input  logic              dat_valid,
  input  logic [BYTE_W-1:0] dat_byte,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word
);
  localparam int IDXW   = $clog2(HALF_BYTES);
  localparam int LPW    = 2 * IDXW;
  localparam int PAGE   = 2 * HALF_BYTES;
  localparam int CNTW   = $clog2(PAGE) + 1;

  logic [7:0]      mode_q;
  logic [CNTW-1:0] cnt;
  logic [1:0]      rd_ptr;
  logic            clr, acc_en, in_out;
  logic [1:0][LPW-1:0]  lp_raw;
  logic [1:0][CP_W-1:0] cp_raw;
  logic [WORD_W-1:0]    word_sel;

  assign clr    = mode_we && (mode_val == MODE_ECC_CLR);
  assign acc_en = (mode_q == MODE_ECC_RUN) && dat_valid && (cnt < CNTW'(PAGE));
  assign in_out = (mode_q == MODE_ECC_OUT);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_DATA;
    else if (mode_we) mode_q <= mode_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (acc_en) cnt <= cnt + 1'b1;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    ecc_half_acc #(.IDXW(IDXW)) u_acc (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .en  (acc_en && (cnt[IDXW] == h[0])),
      .idx (cnt[IDXW-1:0]),
      .din (dat_byte),
      .lp  (lp_raw[h]),
      .cp  (cp_raw[h])
    );
  end

  ecc_result_pack #(.LPW(LPW)) u_pack (
    .lp_a (lp_raw[0]),
    .cp_a (cp_raw[0]),
    .lp_b (lp_raw[1]),
    .cp_b (cp_raw[1]),
    .sel  (rd_ptr),
    .word (word_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
    end else if (mode_we && (mode_val == MODE_ECC_OUT)) begin
      rd_ptr <= '0;
    end else if (in_out && rd_en) begin
      rd_ptr <= (rd_ptr == 2'(N_WORDS - 1)) ? 2'd0 : rd_ptr + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rd_word <= '0;
    else if (in_out && rd_en) rd_word <= word_sel;
  end
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk
  import nand_ecc_pkg::*;
#(
  parameter int CNTW = 10,
  parameter int LPW  = 16,
  parameter int PAGE = 512
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mode_we,
  input logic [7:0]           mode_val,
  input logic [7:0]           mode_q,
  input logic                 dat_valid,
  input logic                 rd_en,
  input logic [WORD_W-1:0]    rd_word,
  input logic [CNTW-1:0]      cnt,
  input logic [1:0]           rd_ptr,
  input logic [1:0][LPW-1:0]  lp_raw,
  input logic [1:0][CP_W-1:0] cp_raw
);
  // R2: clear empties both halves
  p_clear_empties_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_val == MODE_ECC_CLR) |=> (lp_raw == '0 && cp_raw == '0 && cnt == '0));

  // R9: parity frozen outside calculate mode
  p_idle_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_ECC_RUN && !(mode_we && mode_val == MODE_ECC_CLR))
      |=> ($stable(lp_raw) && $stable(cp_raw)));

  // R10: counter bounded and parity frozen when page is full
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(PAGE));
  p_full_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNTW'(PAGE) && !(mode_we && mode_val == MODE_ECC_CLR))
      |=> ($stable(lp_raw) && $stable(cp_raw)));

  // R8: read index in range
  p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ptr < 2'd3);

  // R11: output moves only on a result-mode read
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && mode_q == MODE_ECC_OUT) |=> $stable(rd_word));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.CNTW(CNTW), .LPW(LPW), .PAGE(PAGE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_we   (mode_we),
  .mode_val  (mode_val),
  .mode_q    (mode_q),
  .dat_valid (dat_valid),
  .rd_en     (rd_en),
  .rd_word   (rd_word),
  .cnt       (cnt),
  .rd_ptr    (rd_ptr),
  .lp_raw    (lp_raw),
  .cp_raw    (cp_raw)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        mode_we = 0;
  logic [7:0]  mode_val = 0;
  logic        dat_valid = 0;
  logic [7:0]  dat_byte = 0;
  logic        rd_en = 0;
  logic [15:0] rd_word;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  page [512];
  logic [15:0] exp_w [3];

  always #5 clk = ~clk;

  nand_ecc_gen uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: computes expected words over first n bytes
  task automatic model(input int n);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    lp[0] = 0; lp[1] = 0; cp[0] = 0; cp[1] = 0;
    for (int k = 0; k < n && k < 512; k++) begin
      int h = k / 256;
      int i = k % 256;
      logic p = 0;
      for (int q = 0; q < 8; q++) begin
        if (page[k][q]) begin
          p = ~p;
          if (q % 2 == 0)       cp[h][0] = ~cp[h][0]; else cp[h][1] = ~cp[h][1];
          if ((q / 2) % 2 == 0) cp[h][2] = ~cp[h][2]; else cp[h][3] = ~cp[h][3];
          if (q < 4)            cp[h][4] = ~cp[h][4]; else cp[h][5] = ~cp[h][5];
        end
      end
      for (int j = 0; j < 8; j++)
        if ((i >> j) & 1) lp[h][2*j+1] ^= p; else lp[h][2*j] ^= p;
    end
    exp_w[0] = ~lp[0];
    exp_w[1] = {~lp[1][7:0], ~cp[0], 2'b11};
    exp_w[2] = {~cp[1], 2'b11, ~lp[1][15:8]};
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1; mode_val = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); dat_valid = 1; dat_byte = b;
    @(negedge clk); dat_valid = 0;
  endtask

  task automatic rd(output logic [15:0] w);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; w = rd_word;
  endtask

  task automatic run_page(input int n, input int extra, input string req);
    logic [15:0] w;
    set_mode(8'hF4);
    send(8'h5A);                 // R9: dummy transfer after clear
    set_mode(8'hB4);
    for (int k = 0; k < n; k++) send(page[k]);
    for (int k = 0; k < extra; k++) send(8'h3C);   // R10: beyond page
    set_mode(8'hD4);
    model(n);
    for (int k = 0; k < 3; k++) begin
      rd(w); chk(req, w, exp_w[k]);
    end
    set_mode(8'h94);
  endtask

  initial begin
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset rd_word", rd_word, 16'h0000);
    // R1: empty readout
    set_mode(8'hD4);
    for (int k = 0; k < 3; k++) begin rd(w); chk("R1 empty readout", w, 16'hFFFF); end
    set_mode(8'h94);

    // R6: erased page
    for (int k = 0; k < 512; k++) page[k] = 8'hFF;
    run_page(512, 0, "R6 erased page");

    // R4/R5: single set bit in sparse pages
    for (int k = 0; k < 512; k++) page[k] = 8'h00;
    page[37] = 8'h10;
    run_page(512, 0, "R4 R5 single bit half A");
    page[37] = 8'h00; page[300] = 8'h02;
    run_page(512, 0, "R4 R5 single bit half B");

    // R3/R7: random pages
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 512; k++) page[k] = 8'($urandom);
      run_page(512, 0, "R3 R7 random page");
    end

    // R10: extra bytes after full page
    for (int k = 0; k < 512; k++) page[k] = 8'($urandom);
    run_page(512, 5, "R10 overflow ignored");

    // R3: partial page
    run_page(300, 0, "R3 partial page");

    // R8: wrap and restart; R9: data-mode traffic; R11: read outside result
    for (int k = 0; k < 512; k++) page[k] = 8'($urandom);
    run_page(512, 0, "R7 base");
    send(8'hA5); send(8'h01);            // R9 mode 0x94 traffic
    rd(w); chk("R11 read outside result", w, exp_w[2]);
    set_mode(8'hD4);
    rd(w); chk("R9 R8 restart word0", w, exp_w[0]);
    rd(w); rd(w);
    rd(w); chk("R8 wrap to word0", w, exp_w[0]);
    set_mode(8'hD4);
    rd(w); chk("R8 rewrite restarts", w, exp_w[0]);
    set_mode(8'h94);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule